// File: doc/BRIEF.md
# Signed Array Multiplier (Baugh-Wooley)

This block multiplies two N-bit two's-complement operands and returns their full 2N-bit two's-complement product. It has no clock and no state. The output follows the operands through a regular grid of AND gates and full adders, and then through one ripple-carry row.

Signed operation comes from the bit-level form of the partial products, not from sign extension or subtraction. A partial-product bit whose weight is negative is produced inverted: these are the bits that pair exactly one operand's sign bit with a non-sign bit of the other operand. Two fixed correction ones are then added, one at bit N and one at bit 2N-1. Because of this, every row of the array uses the same cell.

The rows are reduced in carry-save form, and each row is offset by one bit position from the row before it. The last reduction step takes the row that holds most of the sign-weighted terms. A final ripple adder merges the remaining sum and carry vectors. Any carry out of the top bit is dropped. The block is used wherever a signed product is needed in the same cycle the operands are presented.

Top module: `bw_mult`

## Requirements
- R1: For every pair of N-bit two's-complement operands, `prod` equals their signed product as a 2N-bit two's-complement value.
- R2: With both operands at the most negative value (only bit N-1 set), `prod` is the positive value with only bit 2N-2 set.
- R3: When either operand is zero, `prod` is all zeros.
- R4: With both operands all ones (-1), `prod` equals 1.
- R5: The most negative operand times -1 gives `prod` equal to +2^(N-1): only bit N-1 is set and all upper bits are zero.
- R6: When exactly one operand is negative and neither is zero, `prod` is negative, and its upper N bits carry the correct sign extension (for example, max positive times most negative).
- R7: `prod` is purely combinational. It settles to the new result within the same clock period in which the operands change, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | N | First operand, two's complement |
| b_in | input | N | Second operand, two's complement |
| prod | output | 2N | Product, two's complement |

## Verification
Every result is due in the same cycle as its stimulus, after zero clock edges, because no register lies between operands and product. The bench changes operands on the falling edge and compares `prod` 2 ns later, still well before the next rising edge. For R7 it changes the operands a second time inside the same half-period and checks again after a further nanosecond. The default width of 8 allows a sweep of all 65,536 operand pairs. Seeded random pairs and the named corner cases follow the sweep.

// File: rtl/bw_pkg.sv
package bw_pkg;

    typedef struct packed {
        logic s;
        logic c;
    } fa_t;

    function automatic fa_t full_add(input logic a, input logic b, input logic ci);
        fa_t r;
        r.s = a ^ b ^ ci;
        r.c = (a & b) | (a & ci) | (b & ci);
        return r;
    endfunction

endpackage

// File: rtl/bw_pp_gen.sv
module bw_pp_gen #(
    parameter int N = 8
) (
    input  logic [N-1:0]          x,
    input  logic [N-1:0]          y,
    output logic [N-1:0][2*N-1:0] rows
);
    localparam int W = 2 * N;
    localparam logic [W-1:0] CORR = (W'(1) << N) | (W'(1) << (W - 1));

    // Row j holds x*y[j] shifted left by j; sign-weighted bits are inverted.
    always_comb begin
        rows = '0;
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                logic t;
                t = x[i] & y[j];
                if ((i == N - 1) != (j == N - 1)) t = ~t;
                rows[j][i + j] = t;
            end
        end
    end

    logic [W-1:0] acc_chk;
    logic [W-1:0] ref_chk;
    always_comb begin
        acc_chk = CORR;
        for (int j = 0; j < N; j++) acc_chk = acc_chk + rows[j];
        ref_chk = W'({{N{x[N-1]}}, x} * {{N{y[N-1]}}, y});
        AST_ROWS_MATCH: assert (acc_chk == ref_chk) else $error("row set does not sum to product"); // R1
    end

endmodule

// File: rtl/bw_csa_row.sv
module bw_csa_row #(
    parameter int W = 16
) (
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] c_in,
    input  logic [W-1:0] r_in,
    output logic [W-1:0] s_out,
    output logic [W-1:0] c_out
);
    import bw_pkg::*;

    logic [W-2:0] cv;

    for (genvar k = 0; k < W; k++) begin : g_cell
        if (k < W - 1) begin : g_full
            fa_t f;
            assign f        = full_add(s_in[k], c_in[k], r_in[k]);
            assign s_out[k] = f.s;
            assign cv[k]    = f.c;
        end else begin : g_top
            assign s_out[k] = s_in[k] ^ c_in[k] ^ r_in[k];
        end
    end

    assign c_out = {cv, 1'b0};

    always_comb begin
        AST_CSA_CONSERVES: assert (W'(s_out + c_out) == W'(s_in + c_in + r_in)) else $error("carry-save row lost value"); // R1
    end

endmodule

// File: rtl/bw_ripple.sv
module bw_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    import bw_pkg::*;

    always_comb begin
        logic cy;
        fa_t  f;
        cy  = 1'b0;
        sum = '0;
        for (int k = 0; k < W; k++) begin
            f      = full_add(a[k], b[k], cy);
            sum[k] = f.s;
            cy     = f.c;
        end
    end

    always_comb begin
        AST_RIPPLE_SUM: assert (sum == W'(a + b)) else $error("ripple row mismatch"); // R1
    end

endmodule

// File: rtl/bw_mult.sv
module bw_mult #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a_in,
    input  logic [N-1:0]   b_in,
    output logic [2*N-1:0] prod
);
    localparam int W = 2 * N;
    localparam logic [W-1:0] CORR = (W'(1) << N) | (W'(1) << (W - 1));

    logic [N-1:0][W-1:0] rows;
    logic [W-1:0]        st_s [N];
    logic [W-1:0]        st_c [N];

    bw_pp_gen #(.N(N)) u_pp (
        .x    (a_in),
        .y    (b_in),
        .rows (rows)
    );

    assign st_s[0] = rows[0];
    assign st_c[0] = CORR;

    for (genvar j = 1; j < N; j++) begin : g_row
        bw_csa_row #(.W(W)) u_row (
            .s_in  (st_s[j-1]),
            .c_in  (st_c[j-1]),
            .r_in  (rows[j]),
            .s_out (st_s[j]),
            .c_out (st_c[j])
        );
    end

    bw_ripple #(.W(W)) u_fin (
        .a   (st_s[N-1]),
        .b   (st_c[N-1]),
        .sum (prod)
    );

    always_comb begin
        AST_PRODUCT_OK: assert (prod == W'({{N{a_in[N-1]}}, a_in} * {{N{b_in[N-1]}}, b_in})) else $error("product wrong"); // R1
        AST_ZERO_OPERAND: assert (!((a_in == '0) || (b_in == '0)) || (prod == '0)) else $error("zero operand gave nonzero"); // R3
        AST_NEG_ONE_SQUARED: assert (!((a_in == '1) && (b_in == '1)) || (prod == W'(1))) else $error("-1*-1 not 1"); // R4
    end

endmodule

// File: tb/sim_bw_mult.sv
module sim_bw_mult;
    localparam int N = 8;
    localparam int W = 2 * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] a_in, b_in;
    logic [W-1:0] prod;
    int           n_tests = 0;
    int           n_fail  = 0;
    bit           done    = 1'b0;

    always #4 clk = ~clk;

    bw_mult #(.N(N)) u0 (.a_in(a_in), .b_in(b_in), .prod(prod));

    function automatic logic [W-1:0] exp_mul(input logic [N-1:0] x, input logic [N-1:0] y);
        logic signed [W-1:0] xs, ys;
        xs = $signed({{N{x[N-1]}}, x});
        ys = $signed({{N{y[N-1]}}, y});
        return W'(xs * ys);
    endfunction

    task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h got=%h exp=%h", req, a_in, b_in, got, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y);
        @(negedge clk);
        a_in = x;
        b_in = y;
        #2;
    endtask

    localparam logic [N-1:0] MNEG = N'(1) << (N - 1);
    localparam logic [N-1:0] MPOS = ~MNEG;
    localparam logic [N-1:0] ONES = '1;

    initial begin
        a_in = '0;
        b_in = '0;
        repeat (3) @(posedge clk);
        #2;
        chk("R3 reset-time zero inputs", prod, '0);
        rst = 1'b0;

        // R2
        apply(MNEG, MNEG); chk("R2", prod, W'(1) << (W - 2));
        // R3
        apply('0, MNEG);   chk("R3", prod, '0);
        apply(ONES, '0);   chk("R3", prod, '0);
        apply(8'h5a, '0);  chk("R3", prod, '0);
        // R4
        apply(ONES, ONES); chk("R4", prod, W'(1));
        // R5
        apply(MNEG, ONES); chk("R5", prod, W'(1) << (N - 1));
        apply(ONES, MNEG); chk("R5", prod, W'(1) << (N - 1));
        // R6
        apply(MPOS, MNEG); chk("R6", prod, exp_mul(MPOS, MNEG));
        chk("R6 sign", {15'd0, prod[W-1]}, W'(1));
        apply(8'd3, ONES); chk("R6", prod, {W{1'b1}} - W'(2));
        apply(MPOS, MPOS); chk("R1", prod, exp_mul(MPOS, MPOS));

        // R7: two operand changes inside one half-period, no edge between
        @(negedge clk);
        a_in = 8'd9; b_in = 8'd7; #1;
        chk("R7 first", prod, W'(63));
        a_in = 8'hf6; #1;
        chk("R7 second", prod, exp_mul(8'hf6, 8'd7));

        // R1: exhaustive sweep
        for (int i = 0; i < (1 << N); i++) begin
            for (int j = 0; j < (1 << N); j++) begin
                apply(N'(i), N'(j));
                chk("R1 sweep", prod, exp_mul(N'(i), N'(j)));
            end
        end

        // R1: seeded random mix
        void'($urandom(32'd1234));
        for (int k = 0; k < 2000; k++) begin
            logic [N-1:0] x, y;
            x = N'($urandom());
            y = N'($urandom());
            apply(x, y);
            chk("R1 random", prod, exp_mul(x, y));
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog expired got=running exp=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule